// File: doc/BRIEF.md
# Dual-Width Accumulator ALU

This block is the arithmetic and logic unit of an accumulator-style processor whose accumulator and operands can be 8 or 16 bits wide. Each cycle a sequencer may present an operation code, the register operand (the accumulator or an index value), the memory operand, a width select and the current carry flag. One clock later the block returns the result, a write-back enable, and new values for the negative, overflow, zero and carry flags. Each flag has its own update enable, so flags an operation does not own keep their value in the status register outside.

Every operation has its own flag rules. Bit test and compare only set flags. Test-and-set and test-and-reset return a new memory value. Increment and decrement never touch carry or overflow. The byte swap always exchanges the two halves of the full 16-bit register. The block does not fetch operands, form addresses or sequence instructions, and it has no decimal arithmetic. The sequencer picks where a result is written, whether to the accumulator, an index register or memory.

Top module: `dwalu`

## Requirements
- R1: Operation code 0 (add) returns register + memory + carry_in at the selected width. c is set on unsigned carry out. v is set when both operands share a sign and the result sign differs. n is the result MSB and z marks a zero result. All four flags update and the result is written.
- R2: Operation code 1 (subtract) returns register + NOT memory + carry_in. c=1 means no borrow occurred. v follows the add rule with the memory operand inverted. n, v, z and c update and the result is written.
- R3: Operation code 6 (compare) writes no result and leaves v alone. c is set when register >= memory (unsigned). z is set when they are equal. n is the MSB of register minus memory.
- R4: Operation codes 2, 3 and 4 (AND, OR, XOR of register and memory) write the result and update only n and z.
- R5: Operation code 5 (bit test) writes nothing. It sets n from the memory MSB and v from the memory bit just below the MSB (bit 6 at 8 bits, bit 14 at 16 bits). It sets z when register AND memory is zero. c does not update.
- R6: Operation code 7 writes memory OR register, and operation code 8 writes memory AND NOT register. Memory bits whose register bit is clear come back unchanged. Only z updates, set when register AND memory is zero.
- R7: Operation codes 9 and 10 add or subtract one from the register operand and wrap silently. Only n and z update.
- R8: Operation code 11 (shift right) shifts a zero in at the MSB, moves bit 0 into c and leaves n at 0. Operation code 12 (shift left) shifts a zero in at bit 0 and moves the MSB into c. Both update n, z and c and not v.
- R9: Operation code 13 (rotate left) moves carry_in into bit 0 and the MSB into c. Operation code 14 (rotate right) moves carry_in into the MSB and bit 0 into c. Both update n, z and c.
- R10: Operation code 15 swaps bits 15:8 and 7:0 of the register operand at either width. n and z come from the new low byte only, and only n and z update.
- R11: With wide=0 only bits 7:0 of the operands take part and flags use 8-bit positions. Result bits 15:8 equal register bits 15:8, except under R10.
- R12: Outputs are registered, one clock after the inputs. When op_valid is low the write-back and all update enables are 0. A synchronous reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see requirements) |
| wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| reg_opnd | input | 16 | Register operand |
| mem_opnd | input | 16 | Memory operand |
| carry_in | input | 1 | Current carry flag |
| result | output | 16 | Result value |
| res_we | output | 1 | Result should be written back |
| flag_n | output | 1 | New negative flag |
| flag_v | output | 1 | New overflow flag |
| flag_z | output | 1 | New zero flag |
| flag_c | output | 1 | New carry flag |
| upd_n | output | 1 | Apply flag_n |
| upd_v | output | 1 | Apply flag_v |
| upd_z | output | 1 | Apply flag_z |
| upd_c | output | 1 | Apply flag_c |

## Verification
The bench targets sign crossings such as 0x7F+1 and 0x8000-1. A design that took v from the wrong bit or from the unsigned carry would flag the wrong overflow there. It pairs operands that differ only in the upper byte with wide=0. A design that let the upper byte reach the carry, the zero test or the result would differ from the model there. It also checks the flag-ownership corners: increment after a carry-in of 1, bit test with bit 14 set at both widths, and compare with equal operands. In each case a wrong enable would clobber a flag the operation must not touch. It also checks a swap whose upper byte is zero under wide=1, which catches a z taken from all 16 bits.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_BIT  = 4'd5,
    OP_CMP  = 4'd6,
    OP_TSB  = 4'd7,
    OP_TRB  = 4'd8,
    OP_INC  = 4'd9,
    OP_DEC  = 4'd10,
    OP_LSR  = 4'd11,
    OP_ASL  = 4'd12,
    OP_ROL  = 4'd13,
    OP_ROR  = 4'd14,
    OP_SWAP = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic we;
    logic n;
    logic v;
    logic z;
    logic c;
  } upd_t;
endpackage

// File: rtl/dwalu_dec.sv
module dwalu_dec
  import dwalu_pkg::*;
(
  input  alu_op_e op,
  output upd_t    en
);
  always_comb begin
    en = '0;
    unique case (op)
      OP_ADD, OP_SUB:                 en = '{we: 1'b1, n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b1};
      OP_AND, OP_OR, OP_XOR:          en = '{we: 1'b1, n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
      OP_BIT:                         en = '{we: 1'b0, n: 1'b1, v: 1'b1, z: 1'b1, c: 1'b0};
      OP_CMP:                         en = '{we: 1'b0, n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
      OP_TSB, OP_TRB:                 en = '{we: 1'b1, n: 1'b0, v: 1'b0, z: 1'b1, c: 1'b0};
      OP_INC, OP_DEC, OP_SWAP:        en = '{we: 1'b1, n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b0};
      OP_LSR, OP_ASL, OP_ROL, OP_ROR: en = '{we: 1'b1, n: 1'b1, v: 1'b0, z: 1'b1, c: 1'b1};
      default:                        en = '0;
    endcase
  end
endmodule

// File: rtl/dwalu_lane.sv
module dwalu_lane
  import dwalu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   m,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           n,
  output logic           v,
  output logic           z,
  output logic           c
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_sel;
  logic         c_sel;
  logic [W:0]   sum;
  logic         and_zero;

  always_comb begin
    b_sel = (op == OP_ADD) ? m : ~m;
    c_sel = (op == OP_CMP) ? 1'b1 : cin;
    sum   = {1'b0, a} + {1'b0, b_sel} + {{W{1'b0}}, c_sel};
    and_zero = ~|(a & m);
  end

  always_comb begin
    res = sum[W-1:0];
    c   = sum[W];
    v   = (a[MSB] == b_sel[MSB]) && (sum[MSB] != a[MSB]);
    unique case (op)
      OP_AND: res = a & m;
      OP_OR:  res = a | m;
      OP_XOR: res = a ^ m;
      OP_TSB: res = m | a;
      OP_TRB: res = m & ~a;
      OP_INC: res = a + {{(W-1){1'b0}}, 1'b1};
      OP_DEC: res = a - {{(W-1){1'b0}}, 1'b1};
      OP_LSR: begin res = {1'b0, a[MSB:1]};   c = a[0];   end
      OP_ASL: begin res = {a[MSB-1:0], 1'b0}; c = a[MSB]; end
      OP_ROL: begin res = {a[MSB-1:0], cin};  c = a[MSB]; end
      OP_ROR: begin res = {cin, a[MSB:1]};    c = a[0];   end
      default: ;
    endcase
    n = res[MSB];
    z = ~|res;
    if (op == OP_BIT) begin
      n = m[MSB];
      v = m[MSB-1];
    end
    if (op == OP_BIT || op == OP_TSB || op == OP_TRB) z = and_zero;
  end
endmodule

// File: rtl/dwalu.sv
module dwalu
  import dwalu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op,
  input  logic          wide,
  input  logic [DW-1:0] reg_opnd,
  input  logic [DW-1:0] mem_opnd,
  input  logic          carry_in,
  output logic [DW-1:0] result,
  output logic          res_we,
  output logic          flag_n,
  output logic          flag_v,
  output logic          flag_z,
  output logic          flag_c,
  output logic          upd_n,
  output logic          upd_v,
  output logic          upd_z,
  output logic          upd_c
);
  localparam int HW     = DW / 2;
  localparam int NLANES = 2;

  alu_op_e      op_e;
  upd_t         en;
  logic [DW-1:0] lane_res [NLANES];
  logic          lane_n   [NLANES];
  logic          lane_v   [NLANES];
  logic          lane_z   [NLANES];
  logic          lane_c   [NLANES];

  assign op_e = alu_op_e'(op);

  dwalu_dec u_dec (.op(op_e), .en(en));

  for (genvar gi = 0; gi < NLANES; gi++) begin : g_lane
    localparam int LW = (gi == 0) ? HW : DW;
    logic [LW-1:0] lres;
    dwalu_lane #(.W(LW)) u_lane (
      .op  (op_e),
      .a   (reg_opnd[LW-1:0]),
      .m   (mem_opnd[LW-1:0]),
      .cin (carry_in),
      .res (lres),
      .n   (lane_n[gi]),
      .v   (lane_v[gi]),
      .z   (lane_z[gi]),
      .c   (lane_c[gi])
    );
    assign lane_res[gi] = DW'(lres);
  end

  logic [DW-1:0] nxt_res;
  logic          nxt_n, nxt_v, nxt_z, nxt_c;

  always_comb begin
    if (wide) begin
      nxt_res = lane_res[1];
      nxt_n   = lane_n[1];
      nxt_v   = lane_v[1];
      nxt_z   = lane_z[1];
      nxt_c   = lane_c[1];
    end else begin
      nxt_res = {reg_opnd[DW-1:HW], lane_res[0][HW-1:0]};
      nxt_n   = lane_n[0];
      nxt_v   = lane_v[0];
      nxt_z   = lane_z[0];
      nxt_c   = lane_c[0];
    end
    if (op_e == OP_SWAP) begin
      nxt_res = {reg_opnd[HW-1:0], reg_opnd[DW-1:HW]};
      nxt_n   = reg_opnd[DW-1];
      nxt_z   = ~|reg_opnd[DW-1:HW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      res_we <= 1'b0;
      flag_n <= 1'b0;
      flag_v <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      upd_n  <= 1'b0;
      upd_v  <= 1'b0;
      upd_z  <= 1'b0;
      upd_c  <= 1'b0;
    end else begin
      result <= nxt_res;
      flag_n <= nxt_n;
      flag_v <= nxt_v;
      flag_z <= nxt_z;
      flag_c <= nxt_c;
      res_we <= op_valid & en.we;
      upd_n  <= op_valid & en.n;
      upd_v  <= op_valid & en.v;
      upd_z  <= op_valid & en.z;
      upd_c  <= op_valid & en.c;
    end
  end
endmodule

// File: rtl/dwalu_chk.sv
module dwalu_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic [3:0]    op,
  input logic          wide,
  input logic [DW-1:0] reg_opnd,
  input logic [DW-1:0] mem_opnd,
  input logic          carry_in,
  input logic [DW-1:0] result,
  input logic          res_we,
  input logic          flag_n,
  input logic          flag_v,
  input logic          flag_z,
  input logic          flag_c,
  input logic          upd_n,
  input logic          upd_v,
  input logic          upd_z,
  input logic          upd_c
);
  localparam int HW = DW / 2;

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    (!op_valid) |=> (!res_we && !upd_n && !upd_v && !upd_z && !upd_c));

  p_cmp_nowrite_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd6) |=> (!res_we && upd_c && !upd_v));

  p_bit_owns_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd5) |=> (!res_we && upd_v && !upd_c));

  p_incdec_keep_cv_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op == 4'd9 || op == 4'd10)) |=> (!upd_c && !upd_v));

  p_lsr_n_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd11) |=> !flag_n);

  p_tsb_keeps_mem_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd7 && wide) |=> ((result & $past(mem_opnd)) == $past(mem_opnd)));

  p_narrow_high_r11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !wide && op != 4'd15) |=> (result[DW-1:HW] == $past(reg_opnd[DW-1:HW])));

  p_swap_halves_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op == 4'd15) |=> (result[HW-1:0] == $past(reg_opnd[DW-1:HW]) &&
                                   result[DW-1:HW] == $past(reg_opnd[HW-1:0])));
endmodule

bind dwalu dwalu_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_dwalu.sv
module sim_dwalu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op = '0;
  logic        wide = 1'b0;
  logic [15:0] reg_opnd = '0;
  logic [15:0] mem_opnd = '0;
  logic        carry_in = 1'b0;
  logic [15:0] result;
  logic        res_we, flag_n, flag_v, flag_z, flag_c;
  logic        upd_n, upd_v, upd_z, upd_c;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwalu u0 (.*);

  // Expected behaviour computed from the requirements.
  task automatic model(input int o, input bit w, input int r, input int m, input int ci,
                       output int res, output bit [3:0] en_nvzc, output bit we,
                       output bit n, output bit v, output bit z, output bit c);
    int wd, mask, msb, a, b, s, rr, bi;
    wd = w ? 16 : 8;
    mask = (1 << wd) - 1;
    msb = 1 << (wd - 1);
    a = r & mask;
    b = m & mask;
    rr = 0; n = 0; v = 0; z = 0; c = 0; we = 1; en_nvzc = 4'b1010;
    case (o)
      0, 1: begin
        bi = (o == 0) ? b : (~b & mask);
        s = a + bi + ci;
        rr = s & mask;
        c = (s > mask);
        v = (((~(a ^ bi)) & (a ^ rr) & msb) != 0);
        en_nvzc = 4'b1111;
      end
      2: rr = a & b;
      3: rr = a | b;
      4: rr = a ^ b;
      5: begin we = 0; en_nvzc = 4'b1110; end
      6: begin we = 0; en_nvzc = 4'b1011; rr = (a - b) & mask; c = (a >= b); end
      7: begin rr = b | a; en_nvzc = 4'b0010; end
      8: begin rr = b & ~a & mask; en_nvzc = 4'b0010; end
      9: rr = (a + 1) & mask;
      10: rr = (a - 1) & mask;
      11: begin rr = a >> 1; c = a & 1; en_nvzc = 4'b1011; end
      12: begin rr = (a << 1) & mask; c = (a & msb) != 0; en_nvzc = 4'b1011; end
      13: begin rr = ((a << 1) | ci) & mask; c = (a & msb) != 0; en_nvzc = 4'b1011; end
      14: begin rr = (a >> 1) | (ci != 0 ? msb : 0); c = a & 1; en_nvzc = 4'b1011; end
      default: ;
    endcase
    n = (rr & msb) != 0;
    z = (rr == 0);
    if (o == 6) z = (a == b);
    if (o == 5) begin
      n = (b & msb) != 0;
      v = (b & (msb >> 1)) != 0;
    end
    if (o == 5 || o == 7 || o == 8) z = ((a & b) == 0);
    res = w ? rr : ((r & 16'hFF00) | rr);
    if (o == 15) begin
      res = ((r & 8'hFF) << 8) | ((r >> 8) & 8'hFF);
      n = (r & 16'h8000) != 0;
      z = ((r >> 8) & 8'hFF) == 0;
    end
  endtask

  task automatic run_op(input int o, input bit w, input int r, input int m, input int ci,
                        input string req);
    int er;
    bit [3:0] een;
    bit ewe, en_, ev, ez, ec, ok;
    model(o, w, r, m, ci, er, een, ewe, en_, ev, ez, ec);
    @(negedge clk);
    op_valid = 1'b1; op = 4'(o); wide = w;
    reg_opnd = 16'(r); mem_opnd = 16'(m); carry_in = ci[0];
    @(negedge clk);
    op_valid = 1'b0;
    ok = (res_we == ewe) && ({upd_n, upd_v, upd_z, upd_c} == een);
    if (ewe && result != 16'(er)) ok = 0;
    if (een[3] && flag_n != en_) ok = 0;
    if (een[2] && flag_v != ev) ok = 0;
    if (een[1] && flag_z != ez) ok = 0;
    if (een[0] && flag_c != ec) ok = 0;
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s op=%0d w=%0d r=%h m=%h ci=%0d: got res=%h we=%b upd=%b nvzc=%b, exp res=%h we=%b upd=%b nvzc=%b",
               req, o, w, r, m, ci, result, res_we, {upd_n, upd_v, upd_z, upd_c},
               {flag_n, flag_v, flag_z, flag_c}, 16'(er), ewe, een, {en_, ev, ez, ec});
    end
  endtask

  task automatic t_reset;
    checks++;
    if (res_we || upd_n || upd_v || upd_z || upd_c || result != 16'h0) begin
      failures++;
      $display("FAIL R12 reset: got we=%b upd=%b res=%h, exp all 0", res_we,
               {upd_n, upd_v, upd_z, upd_c}, result);
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    op_valid = 1'b0; op = 4'd0; reg_opnd = 16'hFFFF; mem_opnd = 16'h0001;
    @(negedge clk);
    checks++;
    if (res_we || upd_n || upd_v || upd_z || upd_c) begin
      failures++;
      $display("FAIL R12 idle: got we=%b upd=%b, exp 0", res_we, {upd_n, upd_v, upd_z, upd_c});
    end
  endtask

  task automatic t_add;
    run_op(0, 0, 16'h007F, 16'h0001, 0, "R1");
    run_op(0, 0, 16'h00FF, 16'h0001, 0, "R1");
    run_op(0, 1, 16'h7FFF, 16'h0000, 1, "R1");
    run_op(0, 1, 16'hFFFF, 16'hFFFF, 1, "R1");
  endtask

  task automatic t_sub;
    run_op(1, 1, 16'h8000, 16'h0001, 1, "R2");
    run_op(1, 0, 16'h0000, 16'h0001, 1, "R2");
    run_op(1, 0, 16'h0005, 16'h0003, 0, "R2");
  endtask

  task automatic t_cmp;
    run_op(6, 1, 16'h1234, 16'h1234, 0, "R3");
    run_op(6, 0, 16'h0010, 16'h0020, 1, "R3");
    run_op(6, 1, 16'h8000, 16'h7FFF, 0, "R3");
  endtask

  task automatic t_logic;
    run_op(2, 1, 16'hF0F0, 16'h0F0F, 0, "R4");
    run_op(3, 0, 16'h1200, 16'h0080, 1, "R4");
    run_op(4, 1, 16'hA5A5, 16'hA5A5, 1, "R4");
  endtask

  task automatic t_bit;
    run_op(5, 1, 16'h0001, 16'hC000, 0, "R5");
    run_op(5, 0, 16'h0001, 16'h40C1, 1, "R5");
  endtask

  task automatic t_tsbtrb;
    run_op(7, 1, 16'h00F0, 16'h0F0F, 0, "R6");
    run_op(8, 1, 16'h00F0, 16'h0FFF, 0, "R6");
    run_op(8, 0, 16'hAB0F, 16'h00F0, 1, "R6");
  endtask

  task automatic t_incdec;
    run_op(9, 0, 16'h12FF, 16'h0000, 1, "R7");
    run_op(10, 1, 16'h0000, 16'h0000, 1, "R7");
    run_op(9, 1, 16'h7FFF, 16'h0000, 0, "R7");
  endtask

  task automatic t_shift;
    run_op(11, 0, 16'h0081, 16'h0000, 1, "R8");
    run_op(12, 1, 16'h8001, 16'h0000, 0, "R8");
  endtask

  task automatic t_rot;
    run_op(13, 0, 16'h0080, 16'h0000, 1, "R9");
    run_op(14, 1, 16'h0001, 16'h0000, 1, "R9");
  endtask

  task automatic t_swap;
    run_op(15, 1, 16'h00FF, 16'h0000, 0, "R10");
    run_op(15, 0, 16'h8000, 16'h0000, 0, "R10");
  endtask

  task automatic t_narrow;
    run_op(0, 0, 16'hFF01, 16'hFF01, 0, "R11");
    run_op(6, 0, 16'h0080, 16'hFF80, 0, "R11");
  endtask

  function automatic int pick(input int k);
    case (k)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'h007F; 3: return 16'h0080;
      4: return 16'h00FF; 5: return 16'h7FFF; 6: return 16'h8000; 7: return 16'hFFFF;
      8: return 16'h1234; default: return 16'hA5C3;
    endcase
  endfunction

  task automatic t_sweep;
    for (int o = 0; o < 16; o++)
      for (int w = 0; w < 2; w++)
        for (int ci = 0; ci < 2; ci++)
          for (int i = 0; i < 10; i++)
            for (int j = 0; j < 10; j += 3)
              run_op(o, w[0], pick(i), pick(j), ci, "R11 sweep");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_idle();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_bit();
    t_tsbtrb();
    t_incdec();
    t_shift();
    t_rot();
    t_swap();
    t_narrow();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule